// File: doc/BRIEF.md
# Virtualization Transition Trace Packet Generator

This block watches virtualization events reported by a processor core and turns them into a byte stream of trace packets. There are four events: a successful load of a control-structure pointer, a VM entry, a VM exit, and a periodic synchronization burst. The block sends two kinds of packet. A mode packet reports whether the core is in non-root operation. A control-structure packet carries the base address of the active control structure. Bytes leave the block on a valid/ready stream, and an end-of-packet-group marker closes the bytes produced for one event.

Three concealment inputs hide parts of this information. The first keeps the non-root flag and the control-structure packet out of traces taken inside a guest. The second silences exits. The third silences entries. A capability input states whether concealment is supported. If it reads 0 while any concealment bit is set, every entry fails. The block then pulses an entry-failure output and sends nothing for that entry.

Each event is turned at once into a small job, which waits in a 4-entry queue. An output state machine takes jobs from the queue and sends them one byte at a time. Its states are IDLE, SYNC, MODE_HDR, MODE_BODY, CTRL_HDR and CTRL_BODY. IDLE goes to SYNC, MODE_HDR or CTRL_HDR when it pops a job. SYNC goes to MODE_HDR after its sixteenth byte. MODE_HDR goes to MODE_BODY. MODE_BODY goes to CTRL_HDR when the job carries a control-structure packet, and to IDLE when it does not. CTRL_HDR goes to CTRL_BODY. CTRL_BODY goes to IDLE after its fifth byte. Apart from IDLE, each transition happens on an accepted byte.

Top module: `vtt_trace_gen`

## Requirements
- R1: A pointer-load event sends a control-structure packet: byte 0xC8, then address bits [51:12] as five bytes, least significant byte first. Address bits [11:0] are ignored. The loaded base is kept for later packets.
- R2: A mode packet is byte 0x43 followed by one payload byte. Bit 0 of the payload is the non-root flag and bits 7:1 are 0. The first byte of every event's output is a header byte: 0x43, 0xC8, or the first sync byte 0xA5.
- R3: With entry concealment at 0, an entry sends a mode packet whose flag is (destination non-root AND NOT non-root concealment). An entry to management mode then also sends a control-structure packet with the kept base.
- R4: With entry concealment at 1, an entry sends nothing. The non-root state still follows the entry's destination.
- R5: With exit concealment at 0, an exit sends a mode packet with flag 0. An exit to management mode then also sends a control-structure packet with the kept base. Every exit clears the non-root state.
- R6: With exit concealment at 1, an exit sends nothing.
- R7: When capability is 0 and any concealment bit is 1, an entry raises the entry-failure output for exactly the one cycle after the event. No bytes are sent for it and the non-root state is left unchanged. No other event raises the output.
- R8: A sync burst sends 16 bytes, alternating 0xA5 and 0x5A and starting with 0xA5. A mode packet follows, with flag (non-root state AND NOT non-root concealment). A control-structure packet with the kept base comes last, unless the core is non-root and non-root concealment is 1.
- R9: Up to 4 event jobs queue behind the job being sent. An event that finds the queue full is dropped and sets a sticky overflow flag, which only reset clears.
- R10: While a byte is valid and not accepted, valid, data and the last marker hold. The last marker is 1 on the final byte of each event's output. Events are sent in arrival order, and the mode packet comes before the control-structure packet.
- R11: After reset the core is taken as root, the kept base is 0, and out_valid, entry_fail and queue_overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | 0 pointer load, 1 entry, 2 exit, 3 sync burst |
| ev_smm | input | 1 | Entry or exit involves management mode |
| ev_dest_nonroot | input | 1 | Entry destination is non-root |
| ev_addr | input | 52 | Loaded control-structure address |
| cap_conceal | input | 1 | Concealment supported |
| hide_nonroot | input | 1 | Conceal non-root operation |
| hide_entry | input | 1 | Conceal entries |
| hide_exit | input | 1 | Conceal exits |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of an event's output |
| out_ready | input | 1 | Consumer accepts byte |
| entry_fail | output | 1 | Entry refused (one-cycle pulse) |
| queue_overflow | output | 1 | Sticky: an event was dropped |

## Verification
A wrong non-root state or a wrong kept base does not show at once. It appears in the next sync burst, entry or management-mode transition, as a wrong flag bit or wrong address bytes. The bench therefore ends each sequence with events that expose both values. A state machine fault shows within one packet as a misplaced header, a missing last marker or a wrong byte count. A queue fault shows as reordered, lost or duplicated packets in the compared byte stream, or as a wrong overflow flag.

// File: rtl/vtt_pkg.sv
package vtt_pkg;
    localparam int PHYS_AW    = 52;
    localparam int PAGE_SHIFT = 12;
    localparam int BASE_W     = PHYS_AW - PAGE_SHIFT;
    localparam int BASE_BYTES = BASE_W / 8;
    localparam int SYNC_LEN   = 16;

    localparam logic [7:0] MODE_HDR_BYTE = 8'h43;
    localparam logic [7:0] CTRL_HDR_BYTE = 8'hC8;

    typedef enum logic [1:0] {
        EV_PTRLD = 2'd0,
        EV_ENTRY = 2'd1,
        EV_EXIT  = 2'd2,
        EV_SYNC  = 2'd3
    } vtt_event_e;

    typedef struct packed {
        logic              sync;
        logic              mode;
        logic              flag;
        logic              ctrl;
        logic [BASE_W-1:0] base;
    } vtt_job_t;

    function automatic logic [7:0] sync_byte(input logic [3:0] idx);
        return idx[0] ? 8'h5A : 8'hA5;
    endfunction
endpackage

// File: rtl/vtt_event_resolve.sv
module vtt_event_resolve
    import vtt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    input  logic                 ev_smm,
    input  logic                 ev_dest_nonroot,
    input  logic [PHYS_AW-1:0]   ev_addr,
    input  logic                 cap_conceal,
    input  logic                 hide_nonroot,
    input  logic                 hide_entry,
    input  logic                 hide_exit,
    output logic                 push,
    output vtt_job_t             push_job,
    output logic                 entry_fail
);
    vtt_event_e        kind;
    logic              bad_cfg;
    logic              nonroot_q;
    logic [BASE_W-1:0] base_q;
    logic              fail_q;

    assign kind    = vtt_event_e'(ev_kind);
    assign bad_cfg = !cap_conceal && (hide_nonroot || hide_entry || hide_exit);

    always_comb begin
        push_job = '0;
        push     = 1'b0;
        unique case (kind)
            EV_PTRLD: begin
                push_job.ctrl = 1'b1;
                push_job.base = ev_addr[PHYS_AW-1:PAGE_SHIFT];
                push          = ev_valid;
            end
            EV_ENTRY: begin
                push_job.mode = 1'b1;
                push_job.flag = ev_dest_nonroot && !hide_nonroot;
                push_job.ctrl = ev_smm;
                push_job.base = base_q;
                push          = ev_valid && !bad_cfg && !hide_entry;
            end
            EV_EXIT: begin
                push_job.mode = 1'b1;
                push_job.flag = 1'b0;
                push_job.ctrl = ev_smm;
                push_job.base = base_q;
                push          = ev_valid && !hide_exit;
            end
            EV_SYNC: begin
                push_job.sync = 1'b1;
                push_job.mode = 1'b1;
                push_job.flag = nonroot_q && !hide_nonroot;
                push_job.ctrl = !(nonroot_q && hide_nonroot);
                push_job.base = base_q;
                push          = ev_valid;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nonroot_q <= 1'b0;
            base_q    <= '0;
            fail_q    <= 1'b0;
        end else begin
            fail_q <= ev_valid && (kind == EV_ENTRY) && bad_cfg;
            if (ev_valid) begin
                if (kind == EV_PTRLD)
                    base_q <= ev_addr[PHYS_AW-1:PAGE_SHIFT];
                if (kind == EV_ENTRY && !bad_cfg)
                    nonroot_q <= ev_dest_nonroot;
                if (kind == EV_EXIT)
                    nonroot_q <= 1'b0;
            end
        end
    end

    assign entry_fail = fail_q;
endmodule

// File: rtl/vtt_job_fifo.sv
module vtt_job_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, accept, take;
    logic          ovf_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (cnt_q == CW'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign dout   = mem[rd_q];

    always_ff @(posedge clk) begin
        if (accept)
            mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (accept) wr_q <= bump(wr_q);
            if (take)   rd_q <= bump(rd_q);
            if (accept && !take)      cnt_q <= cnt_q + 1'b1;
            else if (take && !accept) cnt_q <= cnt_q - 1'b1;
            if (push && full) ovf_q <= 1'b1;
        end
    end

    assign overflow = ovf_q;
endmodule

// File: rtl/vtt_byte_serializer.sv
module vtt_byte_serializer
    import vtt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       job_empty,
    input  vtt_job_t   job_in,
    output logic       job_pop,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_MODE_HDR,
        ST_MODE_BODY,
        ST_CTRL_HDR,
        ST_CTRL_BODY
    } ser_state_e;

    localparam logic [3:0] SYNC_LAST = 4'(SYNC_LEN - 1);
    localparam logic [3:0] BODY_LAST = 4'(BASE_BYTES - 1);

    ser_state_e state_q, state_d;
    vtt_job_t   job_q;
    logic [3:0] idx_q, idx_d;
    logic       fire;

    assign fire = out_valid && out_ready;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        job_pop = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (!job_empty) begin
                    job_pop = 1'b1;
                    if (job_in.sync)      state_d = ST_SYNC;
                    else if (job_in.mode) state_d = ST_MODE_HDR;
                    else                  state_d = ST_CTRL_HDR;
                end
            end
            ST_SYNC: if (fire) begin
                if (idx_q == SYNC_LAST) begin
                    idx_d   = '0;
                    state_d = ST_MODE_HDR;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_MODE_HDR:  if (fire) state_d = ST_MODE_BODY;
            ST_MODE_BODY: if (fire) state_d = job_q.ctrl ? ST_CTRL_HDR : ST_IDLE;
            ST_CTRL_HDR: if (fire) begin
                idx_d   = '0;
                state_d = ST_CTRL_BODY;
            end
            ST_CTRL_BODY: if (fire) begin
                if (idx_q == BODY_LAST) state_d = ST_IDLE;
                else                    idx_d   = idx_q + 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            job_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (job_pop) job_q <= job_in;
        end
    end

    always_comb begin
        out_valid = 1'b1;
        out_data  = 8'h00;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE:      out_valid = 1'b0;
            ST_SYNC:      out_data  = sync_byte(idx_q);
            ST_MODE_HDR:  out_data  = MODE_HDR_BYTE;
            ST_MODE_BODY: begin
                out_data = {7'b0, job_q.flag};
                out_last = !job_q.ctrl;
            end
            ST_CTRL_HDR:  out_data  = CTRL_HDR_BYTE;
            ST_CTRL_BODY: begin
                out_data = 8'(job_q.base >> {idx_q, 3'b000});
                out_last = (idx_q == BODY_LAST);
            end
            default:      out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/vtt_trace_gen.sv
module vtt_trace_gen
    import vtt_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic [1:0]         ev_kind,
    input  logic               ev_smm,
    input  logic               ev_dest_nonroot,
    input  logic [PHYS_AW-1:0] ev_addr,
    input  logic               cap_conceal,
    input  logic               hide_nonroot,
    input  logic               hide_entry,
    input  logic               hide_exit,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_last,
    input  logic               out_ready,
    output logic               entry_fail,
    output logic               queue_overflow
);
    localparam int JOB_W = $bits(vtt_job_t);

    logic     push, pop, empty;
    vtt_job_t push_job, head_job;

    vtt_event_resolve u_resolve (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_smm(ev_smm),
        .ev_dest_nonroot(ev_dest_nonroot), .ev_addr(ev_addr),
        .cap_conceal(cap_conceal), .hide_nonroot(hide_nonroot),
        .hide_entry(hide_entry), .hide_exit(hide_exit),
        .push(push), .push_job(push_job), .entry_fail(entry_fail)
    );

    vtt_job_fifo #(.W(JOB_W), .DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(push_job),
        .pop(pop), .dout(head_job),
        .empty(empty), .overflow(queue_overflow)
    );

    vtt_byte_serializer u_ser (
        .clk(clk), .rst_n(rst_n),
        .job_empty(empty), .job_in(head_job), .job_pop(pop),
        .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready)
    );
endmodule

// File: rtl/vtt_trace_gen_chk.sv
module vtt_trace_gen_chk
    import vtt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ev_valid,
    input logic [1:0] ev_kind,
    input logic       cap_conceal,
    input logic       hide_nonroot,
    input logic       hide_entry,
    input logic       hide_exit,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       out_ready,
    input logic       entry_fail,
    input logic       queue_overflow
);
    logic sop_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      sop_q <= 1'b1;
        else if (out_valid && out_ready) sop_q <= out_last;
    end

    AST_ENTRY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_kind == EV_ENTRY && !cap_conceal &&
        (hide_nonroot || hide_entry || hide_exit) |=> entry_fail); // R7

    AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fail |-> $past(ev_valid && ev_kind == EV_ENTRY)); // R7

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        queue_overflow |=> queue_overflow); // R9

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R10

    AST_GROUP_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && sop_q |-> (out_data == MODE_HDR_BYTE || out_data == CTRL_HDR_BYTE ||
                                out_data == 8'hA5)); // R2
endmodule

bind vtt_trace_gen vtt_trace_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .cap_conceal(cap_conceal), .hide_nonroot(hide_nonroot),
    .hide_entry(hide_entry), .hide_exit(hide_exit),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .entry_fail(entry_fail), .queue_overflow(queue_overflow)
);

// File: tb/test_vtt_trace_gen.sv
`timescale 1ns/1ps
module test_vtt_trace_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_kind = 2'd0;
    logic        ev_smm = 1'b0;
    logic        ev_dest_nonroot = 1'b0;
    logic [51:0] ev_addr = '0;
    logic        cap_conceal = 1'b0;
    logic        hide_nonroot = 1'b0;
    logic        hide_entry = 1'b0;
    logic        hide_exit = 1'b0;
    logic        out_valid, out_last, out_ready, entry_fail, queue_overflow;
    logic [7:0]  out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int rdy_mode = 0;
    int cyc      = 0;

    logic [7:0]  exp_q[$], got_q[$];
    logic        exp_l[$], got_l[$];
    string       exp_t[$];
    logic        m_nr = 1'b0;
    logic [39:0] m_base = '0;

    always #2.5 clk = ~clk;

    vtt_trace_gen i_vtt_trace_gen (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_smm(ev_smm), .ev_dest_nonroot(ev_dest_nonroot), .ev_addr(ev_addr),
        .cap_conceal(cap_conceal), .hide_nonroot(hide_nonroot),
        .hide_entry(hide_entry), .hide_exit(hide_exit),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .entry_fail(entry_fail), .queue_overflow(queue_overflow)
    );

    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        case (rdy_mode)
            1:       out_ready = (cyc % 3) != 0;
            2:       out_ready = 1'b0;
            default: out_ready = 1'b1;
        endcase
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            got_q.push_back(out_data);
            got_l.push_back(out_last);
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add(input logic [7:0] b, input logic l, input string t);
        exp_q.push_back(b); exp_l.push_back(l); exp_t.push_back(t);
    endtask

    task automatic add_mode(input logic f, input logic l, input string t);
        add(8'h43, 1'b0, t);
        add({7'b0, f}, l, t);
    endtask

    task automatic add_ctrl(input logic [39:0] b, input string t);
        add(8'hC8, 1'b0, t);
        for (int i = 0; i < 5; i++) add(b[i*8 +: 8], i == 4, t);
    endtask

    task automatic wait_out();
        int g = 0;
        while (got_q.size() < exp_q.size() && g < 400) begin
            @(negedge clk); g++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string t);
        check(got_q.size() == exp_q.size(), {t, " R10 byte count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            check(got_q[i] == exp_q[i], {exp_t[i], " data"}, got_q[i], exp_q[i]);
            check(got_l[i] == exp_l[i], {exp_t[i], " R10 last"}, got_l[i], exp_l[i]);
        end
        exp_q.delete(); exp_l.delete(); exp_t.delete(); got_q.delete(); got_l.delete();
    endtask

    // kind: 0 pointer load, 1 entry, 2 exit, 3 sync
    task automatic ev(input logic [1:0] k, input logic smm, input logic dest,
                      input logic [51:0] a, input bit nowait);
        logic bad, fail_exp, inc;
        bad = !cap_conceal && (hide_nonroot || hide_entry || hide_exit);
        fail_exp = 1'b0;
        case (k)
            2'd0: begin
                m_base = a[51:12];
                add_ctrl(m_base, "R1");
            end
            2'd1: begin
                if (bad) fail_exp = 1'b1;
                else begin
                    m_nr = dest;
                    if (!hide_entry) begin
                        add_mode(dest && !hide_nonroot, !smm, "R3");
                        if (smm) add_ctrl(m_base, "R3");
                    end
                end
            end
            2'd2: begin
                m_nr = 1'b0;
                if (!hide_exit) begin
                    add_mode(1'b0, !smm, "R5");
                    if (smm) add_ctrl(m_base, "R5");
                end
            end
            default: begin
                for (int i = 0; i < 16; i++) add(i[0] ? 8'h5A : 8'hA5, 1'b0, "R8");
                inc = !(m_nr && hide_nonroot);
                add_mode(m_nr && !hide_nonroot, !inc, "R8");
                if (inc) add_ctrl(m_base, "R8");
            end
        endcase
        @(posedge clk); #1;
        ev_valid = 1'b1; ev_kind = k; ev_smm = smm; ev_dest_nonroot = dest; ev_addr = a;
        @(posedge clk); #1;
        ev_valid = 1'b0;
        @(negedge clk);
        check(entry_fail == fail_exp, "R7 entry_fail", entry_fail, fail_exp);
        @(negedge clk);
        check(entry_fail == 1'b0, "R7 pulse width", entry_fail, 0);
        if (!nowait) wait_out();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_nr = 1'b0; m_base = '0;
        got_q.delete(); got_l.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        check(entry_fail == 1'b0, "R11 entry_fail", entry_fail, 0);
        check(queue_overflow == 1'b0, "R11 overflow", queue_overflow, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [51:0] a;
        do_reset();
        // R11: base starts at 0, root state
        ev(2'd3, 1'b0, 1'b0, '0, 0);
        compare("R11");
        for (int pass = 0; pass < 2; pass++) begin
            rdy_mode = pass;
            for (int cfg = 0; cfg < 16; cfg++) begin
                cap_conceal = cfg[3]; hide_nonroot = cfg[0];
                hide_entry = cfg[1]; hide_exit = cfg[2];
                a = {4'(cfg + pass), 36'h9_8765_4321, 12'hFFF};
                ev(2'd0, 1'b0, 1'b0, a, 0);          // R1
                ev(2'd3, 1'b0, 1'b0, '0, 0);         // R8 root
                ev(2'd1, 1'b0, 1'b1, '0, 0);         // R3/R4/R7
                ev(2'd3, 1'b0, 1'b0, '0, 0);         // R8 state after entry
                ev(2'd2, 1'b1, 1'b0, '0, 0);         // R5/R6 smm exit
                ev(2'd1, 1'b1, 1'b0, '0, 0);         // R3 smm entry
                ev(2'd1, 1'b0, 1'b1, '0, 0);
                ev(2'd2, 1'b0, 1'b0, '0, 0);         // R5/R6 plain exit
                ev(2'd3, 1'b0, 1'b0, '0, 0);
                compare("sweep");
            end
        end
        // R9: overflow with stalled output
        cap_conceal = 1'b1; hide_nonroot = 1'b0; hide_entry = 1'b0; hide_exit = 1'b0;
        rdy_mode = 2;
        for (int i = 0; i < 5; i++) ev(2'd0, 1'b0, 1'b0, {40'(i + 1), 12'h0}, 1);
        check(queue_overflow == 1'b0, "R9 no overflow at capacity", queue_overflow, 0);
        @(posedge clk); #1;
        ev_valid = 1'b1; ev_kind = 2'd0; ev_addr = {40'hDEAD, 12'h0};
        @(posedge clk); #1 ev_valid = 1'b0;
        @(negedge clk);
        check(queue_overflow == 1'b1, "R9 overflow set", queue_overflow, 1);
        rdy_mode = 0;
        wait_out();
        check(queue_overflow == 1'b1, "R9 overflow sticky", queue_overflow, 1);
        compare("R9");
        do_reset();
        ev(2'd3, 1'b0, 1'b0, '0, 0);
        compare("R11 after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule